// File: doc/BRIEF.md
# Relocatable Standby RAM Controller

This block sits between a 24-bit system bus and a 2 KB on-chip static RAM. Software chooses where the RAM appears in the address map by writing a base-address register, and the RAM answers any access whose upper address bits match that base. The window can be placed on any 2 KB boundary. A disable flag in the same register switches the window off, and the window is switched off when reset releases.

The base register lives in a 64-byte control block. A mapping input places the block at one of two fixed addresses. Only supervisor data-space accesses reach the block, and the block always takes precedence over the RAM window. If software places the window over the control block, accesses to the block still go to the registers and the covered part of the RAM cannot be reached there. The RAM accepts byte, word and long-word transfers from program or data space at either privilege level. It returns an acknowledge, or a bus error for a misaligned transfer, one cycle after the request.

Top module: `reloc_ram_ctrl`

## Requirements
- R1: After reset the window is disabled: the base register reads 0x0001, and array-range accesses get neither acknowledge nor bus error until software clears the disable flag.
- R2: The control block spans 64 bytes from 0x7FFB00 when `map_hi`=0 or from 0xFFFB00 when `map_hi`=1. The base register occupies byte offsets 4 (bits 15:8) and 5 (bits 7:0). Every other offset reads 0x00 and ignores writes.
- R3: The control block responds only when `bus_space`=3'b101 (supervisor data). Any other space code gets no acknowledge and no bus error, and the register does not change.
- R4: Base register layout: bits 15:3 hold the base compared with address bits 23:11, bits 2:1 read zero and ignore writes, and bit 0 is the disable flag (1 = off).
- R5: An access hits the array when the flag is 0, address bits 23:11 equal the base, and `bus_space[1:0]` is 01 (data) or 10 (program), at either privilege (bit 2). Any other access gets no response.
- R6: An address inside the control block never reaches the array, even when the window covers that address. This holds even when the access is refused for privilege.
- R7: Size codes are 01 byte, 10 word and 00 long. Byte lane k (k = address bits 1:0 of that byte) is carried on data bits [31-8k:24-8k]. Reads return zero on lanes that are not enabled, and writes change only the enabled lanes.
- R8: A word at an odd address, a long word at an address that is not a multiple of 4, or size code 11 gets a bus error in place of an acknowledge, and nothing is written.
- R9: The acknowledge or bus error is high only in the cycle after a one-cycle request, and never both at once. `bus_rdata` is zero except in a read's acknowledge cycle.
- R10: The array location is selected by address bits 10:0 alone, so data written before a relocation reads back unchanged through the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_hi | input | 1 | Selects the control block location (0: 0x7FFB00, 1: 0xFFFB00) |
| bus_req | input | 1 | One-cycle access strobe |
| bus_addr | input | 24 | Byte address |
| bus_space | input | 3 | Space code: bit 2 supervisor, bits 1:0 01 data / 10 program |
| bus_siz | input | 2 | Transfer size: 01 byte, 10 word, 00 long |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data, lane k on bits [31-8k:24-8k] |
| bus_ack | output | 1 | Access completed, high in the cycle after the request |
| bus_berr | output | 1 | Misaligned or unsupported size on a hit |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` on reads, otherwise zero |

## Verification
A corrupted base or disable flag shows up on the next access as a missing or unexpected acknowledge at the window boundary, and it can be read back directly through the register. A wrong lane enable shows up in the acknowledge cycle of a read, either as nonzero data on an unused lane or as a byte overwritten by a narrower write. The bench reads the whole array byte by byte after long-word fills, so the damage appears within two cycles of the access that reveals it. Priority and privilege faults are probed with the window placed on top of the control block.

// File: rtl/rr_pkg.sv
// rr_pkg: shared encodings and lane helpers for the relocatable RAM controller.
// Assumes a 32-bit big-endian data bus with lane 0 on bits 31:24.
package rr_pkg;

    localparam logic [1:0] SZ_LONG = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    localparam logic [2:0] SP_SUP_DATA = 3'b101;

    // Lane enables for a transfer: bit k set when byte lane k is moved.
    function automatic logic [3:0] lane_mask(input logic [1:0] siz, input logic [1:0] lo);
        logic [3:0] m;
        case (siz)
            SZ_BYTE: m = 4'b0001 << lo;
            SZ_WORD: m = lo[1] ? 4'b1100 : 4'b0011;
            SZ_LONG: m = 4'b1111;
            default: m = 4'b0000;
        endcase
        return m;
    endfunction

    // True when the size/alignment pair is not a legal transfer.
    function automatic logic bad_align(input logic [1:0] siz, input logic [1:0] lo);
        return (siz == 2'b11) || (siz == SZ_WORD && lo[0]) || (siz == SZ_LONG && lo != 2'b00);
    endfunction

    // Expand lane enables into a 32-bit data mask.
    function automatic logic [31:0] lane_bits(input logic [3:0] m);
        logic [31:0] b;
        for (int k = 0; k < 4; k++) begin
            b[31-8*k -: 8] = {8{m[k]}};
        end
        return b;
    endfunction

endpackage

// File: rtl/rr_decode.sv
// rr_decode: classifies a bus request as register access, array access,
// bus error or miss. Purely combinational; the control block always wins
// over an overlapping window. Assumes REG_LOG2 < WIN_LOG2.
module rr_decode #(
    parameter int          ADDR_W      = 24,
    parameter int          WIN_LOG2    = 11,
    parameter int          REG_LOG2    = 6,
    parameter logic [23:0] REG_BASE_LO = 24'h7FFB00,
    parameter logic [23:0] REG_BASE_HI = 24'hFFFB00,
    localparam int         BASE_W      = ADDR_W - WIN_LOG2
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        space,
    input  logic [1:0]        siz,
    input  logic              map_hi,
    input  logic [BASE_W-1:0] base,
    input  logic              disable_win,
    output logic              reg_go,
    output logic              arr_go,
    output logic              err_go,
    output logic [3:0]        lanes
);
    import rr_pkg::*;

    logic in_blk, in_win, space_ok, reg_hit, arr_hit, misal;
    logic [ADDR_W-1:0] blk_base;

    // Classify the request against the control block and the RAM window.
    always_comb begin
        blk_base = map_hi ? REG_BASE_HI : REG_BASE_LO;
        in_blk   = addr[ADDR_W-1:REG_LOG2] == blk_base[ADDR_W-1:REG_LOG2];
        in_win   = !disable_win && (addr[ADDR_W-1:WIN_LOG2] == base);
        space_ok = (space[1:0] == 2'b01) || (space[1:0] == 2'b10);
        reg_hit  = req && in_blk && (space == SP_SUP_DATA);
        arr_hit  = req && !in_blk && in_win && space_ok;
        misal    = bad_align(siz, addr[1:0]);
        reg_go   = reg_hit && !misal;
        arr_go   = arr_hit && !misal;
        err_go   = (reg_hit || arr_hit) && misal;
        lanes    = lane_mask(siz, addr[1:0]);
    end

endmodule

// File: rtl/rr_regs.sv
// rr_regs: the base-address/disable register inside the control block.
// Register image {base, 2'b00, disable} sits at byte offsets 4..5;
// assumes BASE_W = 13 so that the image is 16 bits.
module rr_regs #(
    parameter  int BASE_W   = 13,
    parameter  int REG_LOG2 = 6,
    localparam int SEL_W    = REG_LOG2 - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  word_sel,
    input  logic [1:0]        lanes_hi,
    input  logic [15:0]       wdata_hi,
    output logic [BASE_W-1:0] base,
    output logic              disable_win,
    output logic [31:0]       rdata
);
    logic hit_word;

    // The base register lives in the long word at byte offset 4.
    assign hit_word = word_sel == SEL_W'(1);

    // Update base and flag from the two upper lanes; bits 2:1 are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base        <= '0;
            disable_win <= 1'b1;
        end else if (we && hit_word) begin
            if (lanes_hi[0]) base[BASE_W-1:5] <= wdata_hi[15:8];
            if (lanes_hi[1]) begin
                base[4:0]   <= wdata_hi[7:3];
                disable_win <= wdata_hi[0];
            end
        end
    end

    // Read image: offsets 4..5 carry the register, everything else is zero.
    always_comb begin
        rdata = hit_word ? {base, 2'b00, disable_win, 16'h0000} : 32'h0;
    end

endmodule

// File: rtl/rr_array.sv
// rr_array: 2^WIN_LOG2-byte static RAM built from four byte-lane memories.
// Read data is registered and held between reads; contents have no reset.
module rr_array #(
    parameter  int WIN_LOG2 = 11,
    localparam int IDX_W    = WIN_LOG2 - 2,
    localparam int WORDS    = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [IDX_W-1:0] idx,
    input  logic [3:0]       lanes,
    input  logic [31:0]      wdata,
    output logic [31:0]      q
);
    for (genvar k = 0; k < 4; k++) begin : g_lane
        logic [7:0] mem [WORDS];

        // Write the enabled lane and capture the lane on reads.
        always_ff @(posedge clk) begin
            if (we && lanes[k]) mem[idx] <= wdata[31-8*k -: 8];
            if (re)             q[31-8*k -: 8] <= mem[idx];
        end
    end

endmodule

// File: rtl/reloc_ram_ctrl.sv
// reloc_ram_ctrl: bus-side controller of a relocatable 2 KB standby RAM.
// Decodes each one-cycle request, performs the access and answers with an
// acknowledge or bus error one cycle later. Assumes requests are one cycle
// wide and at least one idle cycle apart is not required.
module reloc_ram_ctrl #(
    parameter  int          ADDR_W      = 24,
    parameter  int          WIN_LOG2    = 11,
    parameter  int          REG_LOG2    = 6,
    parameter  logic [23:0] REG_BASE_LO = 24'h7FFB00,
    parameter  logic [23:0] REG_BASE_HI = 24'hFFFB00,
    localparam int          BASE_W      = ADDR_W - WIN_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_hi,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_space,
    input  logic [1:0]        bus_siz,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ack,
    output logic              bus_berr,
    output logic [31:0]       bus_rdata
);
    import rr_pkg::*;

    logic              reg_go, arr_go, err_go;
    logic [3:0]        lanes;
    logic [BASE_W-1:0] base;
    logic              disable_win;
    logic [31:0]       reg_rd, arr_q;

    logic              ack_q, err_q, rd_q, src_arr_q;
    logic [3:0]        lanes_q;
    logic [31:0]       reg_rd_q;

    rr_decode #(
        .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .REG_LOG2(REG_LOG2),
        .REG_BASE_LO(REG_BASE_LO), .REG_BASE_HI(REG_BASE_HI)
    ) u_dec (
        .req(bus_req), .addr(bus_addr), .space(bus_space), .siz(bus_siz),
        .map_hi(map_hi), .base(base), .disable_win(disable_win),
        .reg_go(reg_go), .arr_go(arr_go), .err_go(err_go), .lanes(lanes)
    );

    rr_regs #(.BASE_W(BASE_W), .REG_LOG2(REG_LOG2)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(reg_go && bus_wr),
        .word_sel(bus_addr[REG_LOG2-1:2]),
        .lanes_hi(lanes[1:0]),
        .wdata_hi(bus_wdata[31:16]),
        .base(base), .disable_win(disable_win), .rdata(reg_rd)
    );

    rr_array #(.WIN_LOG2(WIN_LOG2)) u_arr (
        .clk(clk),
        .we(arr_go && bus_wr),
        .re(arr_go && !bus_wr),
        .idx(bus_addr[WIN_LOG2-1:2]),
        .lanes(lanes),
        .wdata(bus_wdata),
        .q(arr_q)
    );

    // Second bus cycle: register the response and the read-data source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q     <= 1'b0;
            err_q     <= 1'b0;
            rd_q      <= 1'b0;
            src_arr_q <= 1'b0;
            lanes_q   <= '0;
            reg_rd_q  <= '0;
        end else begin
            ack_q     <= reg_go || arr_go;
            err_q     <= err_go;
            rd_q      <= !bus_wr;
            src_arr_q <= arr_go;
            lanes_q   <= lanes;
            reg_rd_q  <= reg_rd;
        end
    end

    // Drive read data only in a read acknowledge, masked to the enabled lanes.
    always_comb begin
        bus_ack   = ack_q;
        bus_berr  = err_q;
        bus_rdata = (ack_q && rd_q)
                  ? ((src_arr_q ? arr_q : reg_rd_q) & lane_bits(lanes_q))
                  : 32'h0;
    end

endmodule

// File: rtl/rr_checker.sv
// rr_checker: port-level protocol checks for reloc_ram_ctrl, bound below.
// Keeps its own one-cycle history of the request, reset to idle.
module rr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        map_hi,
    input logic        bus_req,
    input logic [23:0] bus_addr,
    input logic [2:0]  bus_space,
    input logic [1:0]  bus_siz,
    input logic        bus_wr,
    input logic        bus_ack,
    input logic        bus_berr,
    input logic [31:0] bus_rdata
);
    import rr_pkg::*;

    logic       req_q, blk_q, mis_q, wr_q;
    logic [2:0] space_q;
    logic [3:0] lanes_q;

    // Remember the previous request as seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            blk_q   <= 1'b0;
            mis_q   <= 1'b0;
            wr_q    <= 1'b0;
            space_q <= 3'b000;
            lanes_q <= 4'b0000;
        end else begin
            req_q   <= bus_req;
            blk_q   <= bus_addr[23:6] == (map_hi ? 18'h3FFEC : 18'h1FFEC);
            mis_q   <= bad_align(bus_siz, bus_addr[1:0]);
            wr_q    <= bus_wr;
            space_q <= bus_space;
            lanes_q <= lane_mask(bus_siz, bus_addr[1:0]);
        end
    end

    assert_ack_berr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack && bus_berr));

    assert_resp_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack || bus_berr) |-> req_q);

    assert_rdata_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack |-> bus_rdata == 32'h0);

    assert_priv_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && blk_q && space_q != SP_SUP_DATA) |-> (!bus_ack && !bus_berr));

    assert_misalign_no_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && mis_q) |-> !bus_ack);

    assert_unused_lanes_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !wr_q) |-> (bus_rdata & ~lane_bits(lanes_q)) == 32'h0);

endmodule

bind reloc_ram_ctrl rr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .map_hi(map_hi), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_space(bus_space), .bus_siz(bus_siz),
    .bus_wr(bus_wr), .bus_ack(bus_ack), .bus_berr(bus_berr),
    .bus_rdata(bus_rdata)
);

// File: tb/reloc_ram_ctrl_tb.sv
// reloc_ram_ctrl_tb: sweeps registers, window, sizes and relocation against
// a bench-side model built from the requirements.
module reloc_ram_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_hi = 1'b0;
    logic        bus_req = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [2:0]  bus_space = '0;
    logic [1:0]  bus_siz = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack, bus_berr;
    logic [31:0] bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    logic [7:0]  mem_m [2048];
    logic [12:0] base_m = '0;
    logic        dis_m  = 1'b1;

    reloc_ram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .map_hi(map_hi), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_space(bus_space), .bus_siz(bus_siz),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_berr(bus_berr), .bus_rdata(bus_rdata)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: expired after %0d cycles, expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'b01) ? 1 : (s == 2'b10) ? 2 : (s == 2'b00) ? 4 : 0;
    endfunction

    function automatic logic [7:0] reg_byte(input logic [5:0] off);
        logic [15:0] img = {base_m, 2'b00, dis_m};
        return (off == 6'd4) ? img[15:8] : (off == 6'd5) ? img[7:0] : 8'h00;
    endfunction

    task automatic check(input string tag, input logic a, input logic e, input logic [31:0] d,
                         input logic xa, input logic xe, input logic [31:0] xd);
        n_tests++;
        if (a !== xa || e !== xe || d !== xd) begin
            n_fail++;
            $display("FAIL %s: ack=%b berr=%b rdata=%h, expected ack=%b berr=%b rdata=%h",
                     tag, a, e, d, xa, xe, xd);
        end
    endtask

    // One access through the ports, with the model predicting the response.
    task automatic run(input string tag, input logic [23:0] a, input logic w,
                       input logic [1:0] s, input logic [2:0] sp, input logic [31:0] wd);
        logic blk, regok, arrok, mis, xa, xe;
        logic [31:0] xd;
        int n;
        logic [23:0] ba;
        logic [7:0] bv;
        blk   = (a >> 6) == ((map_hi ? 24'hFFFB00 : 24'h7FFB00) >> 6);
        regok = blk && sp == 3'b101;
        arrok = !blk && !dis_m && a[23:11] == base_m && (sp[1:0] == 2'b01 || sp[1:0] == 2'b10);
        n     = nbytes(s);
        mis   = (n == 0) || (a % n != 0 && n > 1);
        xa    = (regok || arrok) && !mis;
        xe    = (regok || arrok) && mis;
        xd    = 32'h0;
        if (xa) begin
            for (int k = 0; k < 4; k++) begin
                if (k >= a[1:0] && k < a[1:0] + n) begin
                    ba = {a[23:2], 2'(k)};
                    if (w) begin
                        bv = wd[31-8*k -: 8];
                        if (arrok) mem_m[ba[10:0]] = bv;
                        else if (ba[5:0] == 6'd4) base_m[12:5] = bv;
                        else if (ba[5:0] == 6'd5) begin
                            base_m[4:0] = bv[7:3];
                            dis_m       = bv[0];
                        end
                    end else begin
                        xd[31-8*k -: 8] = arrok ? mem_m[ba[10:0]] : reg_byte(ba[5:0]);
                    end
                end
            end
        end
        @(negedge clk);
        bus_req = 1'b1; bus_addr = a; bus_wr = w; bus_siz = s; bus_space = sp; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        check(tag, bus_ack, bus_berr, bus_rdata, xa, xe, xd);
    endtask

    localparam logic [23:0] RB = 24'h7FFB00;

    initial begin
        logic [23:0] win;
        for (int i = 0; i < 2048; i++) mem_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R9: idle outputs during and right after reset
        check("R9 reset idle", bus_ack, bus_berr, bus_rdata, 1'b0, 1'b0, 32'h0);
        rst_n = 1'b1;

        // R1, R4: reset value of the base register and disabled window
        run("R1 base reg reset", RB + 4, 0, 2'b10, 3'b101, 0);
        run("R1 disabled window", 24'h000000, 0, 2'b00, 3'b001, 0);
        run("R1 disabled window write", 24'h000010, 1, 2'b00, 3'b101, 32'hDEADBEEF);

        // R2: byte sweep of the control block, then writes to unused offsets
        for (int o = 0; o < 64; o++) run("R2 block byte read", RB + o, 0, 2'b01, 3'b101, 0);
        for (int o = 0; o < 64; o++)
            if (o != 4 && o != 5) run("R2 unused write", RB + o, 1, 2'b01, 3'b101, 32'hFFFFFFFF);
        run("R2 reg after unused writes", RB + 4, 0, 2'b00, 3'b101, 0);

        // R3: other spaces never reach the block
        run("R3 user data read", RB + 4, 0, 2'b10, 3'b001, 0);
        run("R3 user data write", RB + 4, 1, 2'b10, 3'b001, 32'h12340000);
        run("R3 super program write", RB + 4, 1, 2'b10, 3'b110, 32'h56780000);
        run("R3 reg unchanged", RB + 4, 0, 2'b10, 3'b101, 0);

        // R4: bits 2:1 drop writes; then set a base and enable
        run("R4 write all ones", RB + 4, 1, 2'b10, 3'b101, 32'hFFFF0000);
        run("R4 read 0xFFF9", RB + 4, 0, 2'b10, 3'b101, 0);
        run("R4 set base 0x123", RB + 4, 1, 2'b10, 3'b101, {13'h0123, 3'b000, 16'h0});
        run("R4 read base", RB + 4, 0, 2'b10, 3'b101, 0);
        run("R4 byte read lo", RB + 5, 0, 2'b01, 3'b101, 0);

        // R2: the other block location
        map_hi = 1'b1;
        run("R2 lo block off when map_hi", RB + 4, 0, 2'b10, 3'b101, 0);
        run("R2 hi block", 24'hFFFB04, 0, 2'b10, 3'b101, 0);
        map_hi = 1'b0;

        // R5, R7: fill the window with long words, read back by bytes and words
        win = {13'h0123, 11'h0};
        for (int i = 0; i < 512; i++)
            run("R7 long fill", win + 24'(4 * i), 1, 2'b00, 3'b101,
                32'(i) * 32'h01030507 ^ 32'h5A3C96E1);
        for (int i = 0; i < 2048; i++)
            run("R5 R7 byte read", win + 24'(i), 0, 2'b01, (i % 2 == 0) ? 3'b001 : 3'b110, 0);
        for (int i = 0; i < 1024; i++)
            run("R7 word read", win + 24'(2 * i), 0, 2'b10, 3'b010, 0);

        // R7: narrow writes change only their lanes
        for (int i = 0; i < 64; i++)
            run("R7 byte write", win + 24'(i), 1, 2'b01, 3'b001, {4{8'(8'hC0 + i)}});
        for (int i = 0; i < 32; i++)
            run("R7 word write", win + 24'(64 + 4 * i + 2 * (i % 2)), 1, 2'b10, 3'b101,
                {2{16'(16'hB000 + i)}});
        for (int i = 0; i < 48; i++)
            run("R7 long readback", win + 24'(4 * i), 0, 2'b00, 3'b101, 0);

        // R8: every size/offset pair, reads and writes, then verify no write
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++) begin
                run("R8 align read", win + 24'(256 + o), 0, 2'(s), 3'b001, 0);
                run("R8 align write", win + 24'(256 + o), 1, 2'(s), 3'b001, 32'hA5A5A5A5);
                run("R8 verify", win + 24'd256, 0, 2'b00, 3'b001, 0);
            end
        run("R8 misaligned reg", RB + 5, 0, 2'b10, 3'b101, 0);

        // R5: window edges and space codes
        run("R5 below window", win - 1, 0, 2'b01, 3'b001, 0);
        run("R5 above window", win + 24'h800, 0, 2'b01, 3'b001, 0);
        run("R5 last byte", win + 24'h7FF, 0, 2'b01, 3'b001, 0);
        run("R5 space 111", win, 0, 2'b00, 3'b111, 0);
        run("R5 space 100", win, 0, 2'b00, 3'b100, 0);

        // R10: relocate and read the same contents through the new window
        run("R10 relocate", RB + 4, 1, 2'b10, 3'b101, {13'h1A5A, 3'b000, 16'h0});
        run("R10 old window gone", win, 0, 2'b00, 3'b001, 0);
        win = {13'h1A5A, 11'h0};
        for (int i = 0; i < 512; i++) run("R10 new window", win + 24'(4 * i), 0, 2'b00, 3'b010, 0);

        // R6: window placed over the control block
        run("R6 overlap base", RB + 4, 1, 2'b10, 3'b101, {13'h0FFF, 3'b000, 16'h0});
        run("R6 reg wins", RB + 4, 0, 2'b10, 3'b101, 0);
        run("R6 user not steered", RB + 4, 0, 2'b10, 3'b001, 0);
        run("R6 user write not steered", RB + 8, 1, 2'b00, 3'b001, 32'h11223344);
        run("R6 outside block hits array", RB + 24'h40, 0, 2'b00, 3'b001, 0);
        for (int o = 0; o < 16; o++) run("R6 covered bytes", RB + 24'(o * 4), 0, 2'b00, 3'b010, 0);
        map_hi = 1'b1;
        for (int o = 0; o < 16; o++) run("R6 uncovered when moved", RB + 24'(o * 4), 0, 2'b00, 3'b010, 0);
        run("R6 hi block reg", 24'hFFFB04, 0, 2'b10, 3'b101, 0);

        // R1: setting the flag turns the window off again
        run("R1 disable", 24'hFFFB05, 1, 2'b01, 3'b101, 32'h00F90000);
        run("R1 window off", RB + 24'h40, 0, 2'b00, 3'b001, 0);
        run("R1 flag readback", 24'hFFFB04, 0, 2'b10, 3'b101, 0);

        repeat (2) @(negedge clk);
        check("R9 idle at end", bus_ack, bus_berr, bus_rdata, 1'b0, 1'b0, 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule